// File: doc/BRIEF.md
# Host Register Access Decoder for an 8-bit Serial Port

This block is the processor-facing front end of an 8-bit serial port. It takes three chip-select inputs of mixed polarity and read and write strobes that each come as an active-high and active-low pair. From these it forms one read enable and one write enable for the current clock cycle. A 3-bit address, extended by a bank-select bit, picks one of ten register slots. The block then either produces a one-hot write strobe for that slot or places the slot's contents on an 8-bit read bus, together with a valid flag.

Six slots are held inside the block: interrupt enable, line control, modem control, scratch, divisor low and divisor high. The other four slots are the receive/transmit data, interrupt identification/FIFO control, line status and modem status. Their read values come in on input ports, and their write and read strobes go out so that the serial engine can act on them. The serial engine, the FIFOs and interrupt prioritisation live elsewhere.

Top module: `hri_top`

## Requirements
- R1: An access is possible only when `cs_a`=1, `cs_b`=1 and `cs_n`=0. In the other seven combinations of these three inputs, `rvalid` and every bit of `wr_stb` and `rd_stb` stay 0.
- R2: A read happens in a cycle where the access condition holds, `rd_p`=1 and `rd_n`=0. `rvalid` is 1 in exactly those cycles, in the same cycle and without a register stage.
- R3: A write happens in a cycle where the access condition holds, `wr_p`=1 and `wr_n`=0. `wr_stb` then has exactly one bit set, at the selected slot index. An internal slot takes `wdata` at that rising edge, and it holds its value in every other cycle.
- R4: When a read and a write are both requested in the same cycle, the read is performed and the write is dropped. `wr_stb` is 0 and the addressed register keeps its value.
- R5: In any cycle without a read, `rdata` is 0.
- R6: The bank bit is bit 7 of the line-control register (slot 3). When it is 1, address 0 reaches divisor low (slot 8) and address 1 reaches divisor high (slot 9). When it is 0, addresses 0 and 1 reach data (slot 0) and interrupt enable (slot 1). `divisor_q` is {slot 9, slot 8}.
- R7: Addresses 2 to 7 select slots 2 to 7 whatever the value of the bank bit.
- R8: While `rst` is 1, every internal slot is cleared at once, without waiting for a clock edge.
- R9: A read of slot 0, 2, 5 or 6 returns `rbr_data`, `iir_data`, `lsr_data` or `msr_data` respectively. `rd_stb` has exactly the bit of the selected slot set.
- R10: A read of an internal slot returns its stored value. `ier_q`, `lcr_q` and `mcr_q` show slots 1, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_p | input | 1 | Read strobe, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_p | input | 1 | Write strobe, active high |
| wr_n | input | 1 | Write strobe, active low |
| rbr_data | input | 8 | Read value for slot 0 (received byte) |
| iir_data | input | 8 | Read value for slot 2 (interrupt identification) |
| lsr_data | input | 8 | Read value for slot 5 (line status) |
| msr_data | input | 8 | Read value for slot 6 (modem status) |
| rdata | output | 8 | Read data, 0 when no read |
| rvalid | output | 1 | High in cycles with a valid read |
| wr_stb | output | 10 | One-hot write strobe per slot |
| rd_stb | output | 10 | One-hot read strobe per slot |
| ier_q | output | 8 | Interrupt-enable register |
| lcr_q | output | 8 | Line-control register (bit 7 is the bank bit) |
| mcr_q | output | 8 | Modem-control register |
| divisor_q | output | 16 | Baud divisor {high, low} |

## Verification
Faults in the qualification logic show at the ports in the same cycle: a wrong polarity opens the decoder under the wrong select or strobe combination, and `rvalid` or `wr_stb` changes at once. A wrong bank bit or a wrong slot mapping sends a write to the wrong register. This becomes visible on the first read-back after the next edge, or at once on `wr_stb` and `divisor_q`. A write that leaks through when a read has priority shows up on the read-back of the scratch slot in the following cycle.

// File: rtl/hri_pkg.sv
package hri_pkg;

    localparam int DW       = 8;
    localparam int AW       = 3;
    localparam int NSEL     = 10;
    localparam int NINT     = 6;
    localparam int BANK_BIT = 7;

    typedef enum logic [3:0] {
        SEL_DATA = 4'd0,
        SEL_IER  = 4'd1,
        SEL_IIR  = 4'd2,
        SEL_LCR  = 4'd3,
        SEL_MCR  = 4'd4,
        SEL_LSR  = 4'd5,
        SEL_MSR  = 4'd6,
        SEL_SCR  = 4'd7,
        SEL_DLL  = 4'd8,
        SEL_DLM  = 4'd9
    } sel_e;

    // positions of the locally held registers in the internal store
    localparam int K_IER = 0;
    localparam int K_LCR = 1;
    localparam int K_MCR = 2;
    localparam int K_SCR = 3;
    localparam int K_DLL = 4;
    localparam int K_DLM = 5;

    typedef struct packed {
        logic rd;
        logic wr;
    } acc_t;

    function automatic sel_e map_sel(logic [AW-1:0] a, logic bank);
        sel_e s;
        if (bank && a == AW'(0))      s = SEL_DLL;
        else if (bank && a == AW'(1)) s = SEL_DLM;
        else                          s = sel_e'({1'b0, a});
        return s;
    endfunction

    function automatic logic [NSEL-1:0] sel_onehot(sel_e s);
        return NSEL'(1) << s;
    endfunction

endpackage

// File: rtl/hri_qualify.sv
module hri_qualify
    import hri_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_a,
    input  logic cs_b,
    input  logic cs_n,
    input  logic rd_p,
    input  logic rd_n,
    input  logic wr_p,
    input  logic wr_n,
    output acc_t acc
);

    logic sel_ok;
    logic rd_req;
    logic wr_req;

    always_comb begin
        sel_ok = cs_a & cs_b & ~cs_n;
        rd_req = sel_ok & rd_p & ~rd_n;
        wr_req = sel_ok & wr_p & ~wr_n;
        acc.rd = rd_req;
        acc.wr = wr_req & ~rd_req;
    end

    AST_RD_NEEDS_STROBES: assert property (@(posedge clk) disable iff (rst)
        acc.rd |-> (rd_p && !rd_n)); // R2

    AST_WR_NEEDS_STROBES: assert property (@(posedge clk) disable iff (rst)
        acc.wr |-> (wr_p && !wr_n)); // R3

endmodule

// File: rtl/hri_decode.sv
module hri_decode
    import hri_pkg::*;
(
    input  logic [AW-1:0]   addr,
    input  logic            bank,
    output sel_e            sel,
    output logic [NSEL-1:0] sel_vec
);

    always_comb begin
        sel     = map_sel(addr, bank);
        sel_vec = sel_onehot(sel);
    end

endmodule

// File: rtl/hri_regfile.sv
module hri_regfile
    import hri_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DW-1:0]            wdata,
    input  logic [NINT-1:0]          wr_int,
    output logic [NINT-1:0][DW-1:0]  q
);

    for (genvar k = 0; k < NINT; k++) begin : g_reg
        always_ff @(posedge clk or posedge rst) begin
            if (rst)            q[k] <= '0;
            else if (wr_int[k]) q[k] <= wdata;
        end
    end

    AST_LCR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_int[K_LCR] |=> $stable(q[K_LCR])); // R3

    AST_SCR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_int[K_SCR] |=> $stable(q[K_SCR])); // R4

endmodule

// File: rtl/hri_rdmux.sv
module hri_rdmux
    import hri_pkg::*;
(
    input  logic                     rd,
    input  logic [NSEL-1:0]          sel_vec,
    input  logic [NSEL-1:0][DW-1:0]  slots,
    output logic [DW-1:0]            rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSEL; i++) begin
            rdata = rdata | (slots[i] & {DW{rd & sel_vec[i]}});
        end
    end

endmodule

// File: rtl/hri_top.sv
module hri_top
    import hri_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    input  logic                cs_a,
    input  logic                cs_b,
    input  logic                cs_n,
    input  logic                rd_p,
    input  logic                rd_n,
    input  logic                wr_p,
    input  logic                wr_n,
    input  logic [DW-1:0]       rbr_data,
    input  logic [DW-1:0]       iir_data,
    input  logic [DW-1:0]       lsr_data,
    input  logic [DW-1:0]       msr_data,
    output logic [DW-1:0]       rdata,
    output logic                rvalid,
    output logic [NSEL-1:0]     wr_stb,
    output logic [NSEL-1:0]     rd_stb,
    output logic [DW-1:0]       ier_q,
    output logic [DW-1:0]       lcr_q,
    output logic [DW-1:0]       mcr_q,
    output logic [2*DW-1:0]     divisor_q
);

    acc_t                    acc;
    sel_e                    sel;
    logic [NSEL-1:0]         sel_vec;
    logic [NINT-1:0]         wr_int;
    logic [NINT-1:0][DW-1:0] reg_q;
    logic [NSEL-1:0][DW-1:0] slots;

    hri_qualify u_qual (
        .clk  (clk),
        .rst  (rst),
        .cs_a (cs_a),
        .cs_b (cs_b),
        .cs_n (cs_n),
        .rd_p (rd_p),
        .rd_n (rd_n),
        .wr_p (wr_p),
        .wr_n (wr_n),
        .acc  (acc)
    );

    hri_decode u_dec (
        .addr    (addr),
        .bank    (reg_q[K_LCR][BANK_BIT]),
        .sel     (sel),
        .sel_vec (sel_vec)
    );

    always_comb begin
        wr_stb = sel_vec & {NSEL{acc.wr}};
        rd_stb = sel_vec & {NSEL{acc.rd}};
        rvalid = acc.rd;

        wr_int[K_IER] = wr_stb[SEL_IER];
        wr_int[K_LCR] = wr_stb[SEL_LCR];
        wr_int[K_MCR] = wr_stb[SEL_MCR];
        wr_int[K_SCR] = wr_stb[SEL_SCR];
        wr_int[K_DLL] = wr_stb[SEL_DLL];
        wr_int[K_DLM] = wr_stb[SEL_DLM];

        slots[SEL_DATA] = rbr_data;
        slots[SEL_IER]  = reg_q[K_IER];
        slots[SEL_IIR]  = iir_data;
        slots[SEL_LCR]  = reg_q[K_LCR];
        slots[SEL_MCR]  = reg_q[K_MCR];
        slots[SEL_LSR]  = lsr_data;
        slots[SEL_MSR]  = msr_data;
        slots[SEL_SCR]  = reg_q[K_SCR];
        slots[SEL_DLL]  = reg_q[K_DLL];
        slots[SEL_DLM]  = reg_q[K_DLM];

        ier_q     = reg_q[K_IER];
        lcr_q     = reg_q[K_LCR];
        mcr_q     = reg_q[K_MCR];
        divisor_q = {reg_q[K_DLM], reg_q[K_DLL]};
    end

    hri_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wdata  (wdata),
        .wr_int (wr_int),
        .q      (reg_q)
    );

    hri_rdmux u_mux (
        .rd      (acc.rd),
        .sel_vec (sel_vec),
        .slots   (slots),
        .rdata   (rdata)
    );

    AST_ACCESS_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        (rvalid || (wr_stb != '0)) |-> (cs_a && cs_b && !cs_n)); // R1

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == '0)); // R5

    AST_READ_WINS: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (wr_stb == '0)); // R4

    AST_DIVISOR_NEEDS_BANK: assert property (@(posedge clk) disable iff (rst)
        (wr_stb[SEL_DLL] || wr_stb[SEL_DLM]) |-> lcr_q[BANK_BIT]); // R6

    AST_RD_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $onehot(rd_stb)); // R9

endmodule

// File: tb/hri_top_tb.sv
module hri_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] RBR_V = 8'hA5;
    localparam logic [7:0] IIR_V = 8'hC1;
    localparam logic [7:0] LSR_V = 8'h60;
    localparam logic [7:0] MSR_V = 8'hB0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        cs_a = 1'b0, cs_b = 1'b0, cs_n = 1'b1;
    logic        rd_p = 1'b0, rd_n = 1'b1, wr_p = 1'b0, wr_n = 1'b1;
    logic [7:0]  rdata;
    logic        rvalid;
    logic [9:0]  wr_stb, rd_stb;
    logic [7:0]  ier_q, lcr_q, mcr_q;
    logic [15:0] divisor_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] m [10];

    always #(CLK_PERIOD/2) clk = ~clk;

    hri_top u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .cs_a(cs_a), .cs_b(cs_b), .cs_n(cs_n),
        .rd_p(rd_p), .rd_n(rd_n), .wr_p(wr_p), .wr_n(wr_n),
        .rbr_data(RBR_V), .iir_data(IIR_V), .lsr_data(LSR_V), .msr_data(MSR_V),
        .rdata(rdata), .rvalid(rvalid), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .ier_q(ier_q), .lcr_q(lcr_q), .mcr_q(mcr_q), .divisor_q(divisor_q)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int slot_of(input logic [2:0] a);
        return (m[3][7] && a < 3'd2) ? 8 + int'(a) : int'(a);
    endfunction

    function automatic logic [7:0] slot_val(input int s);
        case (s)
            0: return RBR_V;
            2: return IIR_V;
            5: return LSR_V;
            6: return MSR_V;
            default: return m[s];
        endcase
    endfunction

    function automatic bit is_int(input int s);
        return !(s == 0 || s == 2 || s == 5 || s == 6);
    endfunction

    task automatic drive(input logic [2:0] cs, input logic [3:0] st, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        {cs_a, cs_b, cs_n} = cs;
        {rd_p, rd_n, wr_p, wr_n} = st;
        addr = a;
        wdata = d;
        #1;
    endtask

    task automatic idle();
        drive(3'b001, 4'b0101, 3'd0, 8'h00);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        int s;
        s = slot_of(a);
        drive(3'b110, 4'b0110, a, d);
        check(wr_stb == 10'(1 << s), "R3 write strobe", 32'(wr_stb), 32'(1 << s));
        if (is_int(s)) m[s] = d;
    endtask

    task automatic rd(input logic [2:0] a, input string req);
        int s;
        s = slot_of(a);
        drive(3'b110, 4'b1001, a, 8'h00);
        check(rvalid && rdata == slot_val(s), req, {23'd0, rvalid, rdata}, {23'd0, 1'b1, slot_val(s)});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int acc_cnt;
        for (int i = 0; i < 10; i++) m[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check(lcr_q == 0 && ier_q == 0 && mcr_q == 0 && divisor_q == 0, "R8 reset state",
              {lcr_q, ier_q, mcr_q, 8'h0}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        idle();
        check(!rvalid && rdata == 0 && wr_stb == 0, "R5 idle outputs", {23'd0, rvalid, rdata}, 32'h0);

        // R1: all eight chip-select combinations with a valid read strobe
        acc_cnt = 0;
        for (int c = 0; c < 8; c++) begin
            bit exp_acc;
            exp_acc = (c == 3'b110);
            drive(3'(c), 4'b1001, 3'd5, 8'h00);
            if (rvalid) acc_cnt++;
            check(rvalid == exp_acc && (rd_stb != 0) == exp_acc, "R1 chip-select combo",
                  {22'd0, rvalid, rd_stb != 0, 8'(c)}, {22'd0, exp_acc, exp_acc, 8'(c)});
            check(rdata == (exp_acc ? LSR_V : 8'h00), "R5 rdata on no-access", 32'(rdata), 32'(exp_acc ? LSR_V : 8'h00));
        end
        for (int c = 0; c < 8; c++) begin
            drive(3'(c), 4'b0110, 3'd7, 8'h5A);
            check((wr_stb != 0) == (c == 3'b110), "R1 write chip-select combo", 32'(wr_stb), 32'(c == 3'b110 ? 10'h080 : 10'h0));
            if (c == 3'b110) m[7] = 8'h5A;
        end
        check(acc_cnt == 1, "R1 single enabling combo", 32'(acc_cnt), 32'd1);
        rd(3'd7, "R3 scratch after sweep");

        // R2 R3 R4: all sixteen strobe combinations on the scratch slot
        for (int s = 0; s < 16; s++) begin
            bit er, ew;
            logic [7:0] d;
            er = s[3] && !s[2];
            ew = s[1] && !s[0] && !er;
            d  = 8'h10 + 8'(s);
            drive(3'b110, 4'(s), 3'd7, d);
            check(rvalid == er, "R2 read strobe pair", 32'(rvalid), 32'(er));
            check(wr_stb == (ew ? 10'h080 : 10'h000), "R4 write strobe / priority", 32'(wr_stb), 32'(ew ? 10'h080 : 10'h0));
            check(rdata == (er ? m[7] : 8'h00), "R5 rdata per strobe combo", 32'(rdata), 32'(er ? m[7] : 8'h00));
            if (ew) m[7] = d;
            rd(3'd7, "R4 scratch read-back");
        end

        // R10: internal registers with bank bit clear
        wr(3'd1, 8'h0F);
        wr(3'd4, 8'h13);
        wr(3'd3, 8'h1B);
        idle();
        check(ier_q == 8'h0F && mcr_q == 8'h13 && lcr_q == 8'h1B, "R10 register outputs",
              {8'h0, ier_q, mcr_q, lcr_q}, 32'h000F131B);
        rd(3'd1, "R10 read IER");
        rd(3'd4, "R10 read MCR");
        rd(3'd3, "R10 read LCR");

        // R9: external slots and read strobes
        for (int a = 0; a < 8; a++) begin
            drive(3'b110, 4'b1001, 3'(a), 8'h00);
            check(rd_stb == 10'(1 << a), "R9 read strobe", 32'(rd_stb), 32'(1 << a));
            check(rdata == slot_val(a), "R9 read value bank 0", 32'(rdata), 32'(slot_val(a)));
        end

        // R6: bank bit set
        wr(3'd3, 8'h9B);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        idle();
        check(divisor_q == 16'h1234 && ier_q == 8'h0F, "R6 divisor via bank", {divisor_q, ier_q, 8'h0}, 32'h12340F00);
        rd(3'd0, "R6 read divisor low");
        rd(3'd1, "R6 read divisor high");
        // R7: addresses 2..7 unaffected by the bank bit
        for (int a = 2; a < 8; a++) begin
            drive(3'b110, 4'b1001, 3'(a), 8'h00);
            check(rd_stb == 10'(1 << a) && rdata == slot_val(a), "R7 high address with bank set",
                  {14'd0, rd_stb, rdata}, {14'd0, 10'(1 << a), slot_val(a)});
        end
        wr(3'd3, 8'h1B);
        wr(3'd0, 8'h77);
        idle();
        check(divisor_q == 16'h1234, "R6 data write leaves divisor", 32'(divisor_q), 32'h1234);
        rd(3'd0, "R6 address 0 back to data");
        rd(3'd1, "R6 address 1 back to IER");

        // R8: asynchronous clear between edges
        wr(3'd7, 8'hE7);
        idle();
        @(negedge clk);
        #2 rst = 1'b1;
        #1;
        check(lcr_q == 0 && ier_q == 0 && mcr_q == 0 && divisor_q == 0, "R8 async clear",
              {lcr_q, ier_q, mcr_q, 8'h0}, 32'h0);
        for (int i = 0; i < 10; i++) m[i] = 8'h00;
        @(negedge clk);
        rst = 1'b0;
        rd(3'd7, "R8 scratch cleared");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule